// File: doc/BRIEF.md
# Block-Keyed Storage Protection Checker

This block sits beside the storage port of a communication controller and judges every access that a program level or a cycle-stealing unit presents. Storage is divided into 2048-byte blocks; each installed block carries a 3-bit storage key, a read-only flag and an address-exception flag in a small internal attribute array. Each requester owns a 3-bit user key. For each access the checker combines the access kind (instruction fetch, data read, data write), the access size, the 23-bit computed address and these attributes. It reports at most one violation, with a 2-bit cause, in the cycle after the access. The access itself is never stalled.

The keys and flags are changed through a small update port. An update takes effect only when the requester that issues it currently holds user key 0. An exit event from a program level clears that level's user key, except for the last level, whose key is kept. Addresses past the top of the 22-bit space wrap around. The physical address of every accepted access is returned so that the caller can see the wrapped value.

Top module: `stor_prot_chk`

## Requirements
- R1: An instruction fetch (access kind 0) raises a key violation (cause 1) unless the requester's user key equals the block's storage key exactly.
- R2: A data write (kind 2) raises a key violation (cause 1) unless the keys are equal, or the storage key is 7, or the user key is 0. A data read (kind 1; the unused kind 3 is also treated as a read) is never key-checked.
- R3: A data write to a block whose read-only flag is set raises cause 2, even when the key check passes.
- R4: An access to a block whose address-exception flag is set, or to an address at or beyond NUM_BLK*2048 bytes (the installed size), raises cause 3.
- R5: A computed address above 0x3FFFFF is mapped to the address minus 0x3FFFFF and returned on acc_phys. Such a wrapped access raises cause 3 only while prot_en is high. The address 0x3FFFFF itself does not wrap.
- R6: A halfword (size 1) or fullword (size 2) access at an odd address raises an alignment violation (cause 0). Byte accesses (size 0) are never misaligned.
- R7: When several violations apply, one cause is reported, in the order 3 over 0 over 1 over 2.
- R8: viol_valid and acc_phys are registered. They reflect the access presented in the previous cycle. viol_valid is a single-cycle pulse that is only ever raised in the cycle after acc_valid.
- R9: An update (upd_sel 0 = user key of requester upd_idx, 1 = storage key of block upd_idx, 2 = read-only flag from upd_data[0], 3 = address-exception flag from upd_data[0]) takes effect at the next clock edge only if requester upd_req holds user key 0. Otherwise nothing changes.
- R10: An exit on level L (1 to NUM_LVL-1) clears the user key of requester L-1. An exit on level NUM_LVL leaves its key unchanged. An exit clear wins over an update of the same key in the same cycle.
- R11: After reset all user keys, storage keys and flags are 0 and viol_valid is low. Requesters 0 to NUM_LVL-1 are levels 1 to NUM_LVL, and the following indices are the cycle-stealing units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en | input | 1 | Enables the exception on wrapped addresses |
| acc_valid | input | 1 | Access present this cycle |
| acc_req | input | REQ_W (3) | Requester index of the access |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 fullword |
| acc_addr | input | ADDR_W+1 (23) | Computed address before wrapping |
| upd_valid | input | 1 | Attribute update request |
| upd_req | input | REQ_W (3) | Requester issuing the update |
| upd_sel | input | 2 | Which attribute is written |
| upd_idx | input | UIDX_W (5) | Target requester or block index |
| upd_data | input | KEY_W (3) | New key, or flag in bit 0 |
| exit_valid | input | 1 | Program level exit event |
| exit_level | input | LVL_W (3) | Exiting level, 1 to NUM_LVL |
| viol_valid | output | 1 | Violation pulse for the previous access |
| viol_cause | output | 2 | 0 alignment, 1 key, 2 read-only, 3 address exception |
| acc_phys | output | ADDR_W (22) | Physical address of the previous access |

## Verification
On every cycle the in-line assertions check these properties:
- a violation pulse is never raised without an access in the cycle before;
- a wrapped address is returned with the wrap constant taken off;
- an exit on a lower level leaves that level's key at zero, and an exit on the last level leaves its key alone;
- an update refused for lack of privilege changes no block attribute.

The decision itself is shown only by the bench's scenarios. These cover the exact-match rule for fetches against the escape rules for writes, and the ordering of the four causes. They also cover the installed-size edge and the wrap edge, the refused update seen through a later fetch, and the exit-against-update race seen through the cause of a following write.

// File: rtl/stor_prot_pkg.sv
package stor_prot_pkg;

   typedef enum logic [1:0] {
      KIND_FETCH = 2'd0,
      KIND_READ  = 2'd1,
      KIND_WRITE = 2'd2,
      KIND_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      SIZE_BYTE = 2'd0,
      SIZE_HALF = 2'd1,
      SIZE_FULL = 2'd2,
      SIZE_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      SEL_USER_KEY = 2'd0,
      SEL_BLK_KEY  = 2'd1,
      SEL_RO_FLAG  = 2'd2,
      SEL_AE_FLAG  = 2'd3
   } upd_sel_e;

   localparam logic [1:0] CAUSE_ALIGN = 2'd0;
   localparam logic [1:0] CAUSE_KEY   = 2'd1;
   localparam logic [1:0] CAUSE_RDONLY = 2'd2;
   localparam logic [1:0] CAUSE_ADDR  = 2'd3;

endpackage

// File: rtl/stor_prot_user_keys.sv
module stor_prot_user_keys #(
   parameter int NUM_LVL = 5,
   parameter int NUM_CS  = 2,
   parameter int KEY_W   = 3,
   localparam int NUM_REQ = NUM_LVL + NUM_CS,
   localparam int REQ_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
   localparam int LVL_W   = $clog2(NUM_LVL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REQ_W-1:0] wr_idx,
   input  logic [KEY_W-1:0] wr_data,
   input  logic             exit_valid,
   input  logic [LVL_W-1:0] exit_level,
   input  logic [REQ_W-1:0] rd_a_idx,
   output logic [KEY_W-1:0] rd_a_key,
   input  logic [REQ_W-1:0] rd_b_idx,
   output logic [KEY_W-1:0] rd_b_key
);

   logic [KEY_W-1:0] key_q [NUM_REQ];

   generate
      if (NUM_LVL < 1) begin : g_bad_lvl
         $error("stor_prot_user_keys: NUM_LVL must be at least 1");
      end
      for (genvar gi = 0; gi < NUM_REQ; gi++) begin : g_key
         logic hit_wr;
         logic hit_exit;
         assign hit_wr = wr_en && (wr_idx == REQ_W'(gi));
         if (gi < NUM_LVL - 1) begin : g_clearable
            assign hit_exit = exit_valid && (exit_level == LVL_W'(gi + 1));
         end else begin : g_kept
            assign hit_exit = 1'b0;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               key_q[gi] <= '0;
            end else if (hit_exit) begin
               key_q[gi] <= '0;
            end else if (hit_wr) begin
               key_q[gi] <= wr_data;
            end
         end

         if (gi < NUM_LVL - 1) begin : g_chk_clear
            assert_exit_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
               (exit_valid && exit_level == LVL_W'(gi + 1)) |=> (key_q[gi] == '0));
         end
      end
   endgenerate

   assert_last_level_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (exit_valid && exit_level == LVL_W'(NUM_LVL) &&
       !(wr_en && wr_idx == REQ_W'(NUM_LVL - 1)))
      |=> $stable(key_q[NUM_LVL-1]));

   always_comb begin
      rd_a_key = '1;
      rd_b_key = '1;
      for (int i = 0; i < NUM_REQ; i++) begin
         if (rd_a_idx == REQ_W'(i)) rd_a_key = key_q[i];
         if (rd_b_idx == REQ_W'(i)) rd_b_key = key_q[i];
      end
   end

endmodule

// File: rtl/stor_prot_blk_attr.sv
module stor_prot_blk_attr
   import stor_prot_pkg::*;
#(
   parameter int NUM_BLK = 32,
   parameter int KEY_W   = 3,
   localparam int BIDX_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [BIDX_W-1:0] wr_idx,
   input  logic [KEY_W-1:0]  wr_data,
   input  logic              wr_refused,
   input  logic [BIDX_W-1:0] rd_idx,
   output logic [KEY_W-1:0]  rd_key,
   output logic              rd_ro,
   output logic              rd_ae
);

   logic [KEY_W-1:0] skey_q [NUM_BLK];
   logic             ro_q   [NUM_BLK];
   logic             ae_q   [NUM_BLK];

   generate
      if (NUM_BLK < 1) begin : g_bad_blk
         $error("stor_prot_blk_attr: NUM_BLK must be at least 1");
      end
      for (genvar gb = 0; gb < NUM_BLK; gb++) begin : g_blk
         logic sel_me;
         assign sel_me = wr_en && (wr_idx == BIDX_W'(gb));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               skey_q[gb] <= '0;
               ro_q[gb]   <= 1'b0;
               ae_q[gb]   <= 1'b0;
            end else if (sel_me) begin
               case (upd_sel_e'(wr_sel))
                  SEL_BLK_KEY: skey_q[gb] <= wr_data;
                  SEL_RO_FLAG: ro_q[gb]   <= wr_data[0];
                  SEL_AE_FLAG: ae_q[gb]   <= wr_data[0];
                  default:     ;
               endcase
            end
         end

         assert_refused_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
            wr_refused |=> ($stable(skey_q[gb]) && $stable(ro_q[gb]) && $stable(ae_q[gb])));
      end
   endgenerate

   always_comb begin
      rd_key = '0;
      rd_ro  = 1'b0;
      rd_ae  = 1'b0;
      for (int i = 0; i < NUM_BLK; i++) begin
         if (rd_idx == BIDX_W'(i)) begin
            rd_key = skey_q[i];
            rd_ro  = ro_q[i];
            rd_ae  = ae_q[i];
         end
      end
   end

endmodule

// File: rtl/stor_prot_judge.sv
module stor_prot_judge
   import stor_prot_pkg::*;
#(
   parameter int KEY_W = 3
) (
   input  logic [1:0]       kind,
   input  logic [1:0]       size,
   input  logic             addr_lsb,
   input  logic             out_of_range,
   input  logic             blk_ae,
   input  logic             wrapped,
   input  logic             prot_en,
   input  logic [KEY_W-1:0] user_key,
   input  logic [KEY_W-1:0] blk_key,
   input  logic             blk_ro,
   output logic             hit,
   output logic [1:0]       cause
);

   localparam logic [KEY_W-1:0] OPEN_KEY = '1;

   logic addr_exc, misalign, key_bad, ro_bad, keys_equal;

   always_comb begin
      keys_equal = (user_key == blk_key);
      addr_exc   = out_of_range || blk_ae || (wrapped && prot_en);
      misalign   = (acc_size_e'(size) != SIZE_BYTE) && addr_lsb;
      case (acc_kind_e'(kind))
         KIND_FETCH: key_bad = !keys_equal;
         KIND_WRITE: key_bad = !keys_equal && (blk_key != OPEN_KEY) && (user_key != '0);
         default:    key_bad = 1'b0;
      endcase
      ro_bad = (acc_kind_e'(kind) == KIND_WRITE) && blk_ro;

      hit   = addr_exc || misalign || key_bad || ro_bad;
      if (addr_exc)      cause = CAUSE_ADDR;
      else if (misalign) cause = CAUSE_ALIGN;
      else if (key_bad)  cause = CAUSE_KEY;
      else               cause = CAUSE_RDONLY;
   end

endmodule

// File: rtl/stor_prot_chk.sv
module stor_prot_chk
   import stor_prot_pkg::*;
#(
   parameter int ADDR_W    = 22,
   parameter int BLK_SHIFT = 11,
   parameter int NUM_BLK   = 32,
   parameter int NUM_LVL   = 5,
   parameter int NUM_CS    = 2,
   parameter int KEY_W     = 3,
   localparam int NUM_REQ  = NUM_LVL + NUM_CS,
   localparam int REQ_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
   localparam int BIDX_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
   localparam int UIDX_W   = (BIDX_W > REQ_W) ? BIDX_W : REQ_W,
   localparam int LVL_W    = $clog2(NUM_LVL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_en,
   input  logic              acc_valid,
   input  logic [REQ_W-1:0]  acc_req,
   input  logic [1:0]        acc_kind,
   input  logic [1:0]        acc_size,
   input  logic [ADDR_W:0]   acc_addr,
   input  logic              upd_valid,
   input  logic [REQ_W-1:0]  upd_req,
   input  logic [1:0]        upd_sel,
   input  logic [UIDX_W-1:0] upd_idx,
   input  logic [KEY_W-1:0]  upd_data,
   input  logic              exit_valid,
   input  logic [LVL_W-1:0]  exit_level,
   output logic              viol_valid,
   output logic [1:0]        viol_cause,
   output logic [ADDR_W-1:0] acc_phys
);

   localparam int BLKNUM_W = ADDR_W - BLK_SHIFT;
   localparam logic [ADDR_W:0] WRAP_PT = {1'b0, {ADDR_W{1'b1}}};

   generate
      if (BLK_SHIFT >= ADDR_W) begin : g_bad_shift
         $error("stor_prot_chk: BLK_SHIFT must be below ADDR_W");
      end
      if (BIDX_W > BLKNUM_W) begin : g_bad_blk
         $error("stor_prot_chk: NUM_BLK exceeds the address space");
      end
      if (KEY_W < 1) begin : g_bad_key
         $error("stor_prot_chk: KEY_W must be positive");
      end
   endgenerate

   // address wrap and block decode
   logic              wrapped;
   logic [ADDR_W:0]   wrapped_sum;
   logic [ADDR_W-1:0] phys;
   logic [BLKNUM_W-1:0] blk_num;
   logic              out_of_range;
   logic [BIDX_W-1:0] blk_idx;

   always_comb begin
      wrapped     = acc_addr > WRAP_PT;
      wrapped_sum = acc_addr - WRAP_PT;
      phys        = wrapped ? wrapped_sum[ADDR_W-1:0] : acc_addr[ADDR_W-1:0];
      blk_num     = phys[ADDR_W-1:BLK_SHIFT];
      out_of_range = 32'(blk_num) >= NUM_BLK;
      blk_idx     = blk_num[BIDX_W-1:0];
   end

   // key lookups and update gating
   logic [KEY_W-1:0] acc_ukey, upd_ukey;
   logic             upd_priv;
   logic             uk_wr_en, blk_wr_en, blk_refused;

   always_comb begin
      upd_priv    = (upd_ukey == '0);
      uk_wr_en    = upd_valid && upd_priv && (upd_sel_e'(upd_sel) == SEL_USER_KEY) &&
                    (32'(upd_idx) < NUM_REQ);
      blk_wr_en   = upd_valid && upd_priv && (upd_sel_e'(upd_sel) != SEL_USER_KEY) &&
                    (32'(upd_idx) < NUM_BLK);
      blk_refused = upd_valid && !upd_priv;
   end

   stor_prot_user_keys #(
      .NUM_LVL (NUM_LVL),
      .NUM_CS  (NUM_CS),
      .KEY_W   (KEY_W)
   ) u_user_keys (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (uk_wr_en),
      .wr_idx     (upd_idx[REQ_W-1:0]),
      .wr_data    (upd_data),
      .exit_valid (exit_valid),
      .exit_level (exit_level),
      .rd_a_idx   (acc_req),
      .rd_a_key   (acc_ukey),
      .rd_b_idx   (upd_req),
      .rd_b_key   (upd_ukey)
   );

   logic [KEY_W-1:0] blk_key;
   logic             blk_ro, blk_ae;

   stor_prot_blk_attr #(
      .NUM_BLK (NUM_BLK),
      .KEY_W   (KEY_W)
   ) u_blk_attr (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (blk_wr_en),
      .wr_sel     (upd_sel),
      .wr_idx     (upd_idx[BIDX_W-1:0]),
      .wr_data    (upd_data),
      .wr_refused (blk_refused),
      .rd_idx     (blk_idx),
      .rd_key     (blk_key),
      .rd_ro      (blk_ro),
      .rd_ae      (blk_ae)
   );

   // decision
   logic       judge_hit;
   logic [1:0] judge_cause;

   stor_prot_judge #(
      .KEY_W (KEY_W)
   ) u_judge (
      .kind         (acc_kind),
      .size         (acc_size),
      .addr_lsb     (phys[0]),
      .out_of_range (out_of_range),
      .blk_ae       (blk_ae),
      .wrapped      (wrapped),
      .prot_en      (prot_en),
      .user_key     (acc_ukey),
      .blk_key      (blk_key),
      .blk_ro       (blk_ro),
      .hit          (judge_hit),
      .cause        (judge_cause)
   );

   // result register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol_valid <= 1'b0;
         viol_cause <= CAUSE_ALIGN;
         acc_phys   <= '0;
      end else begin
         viol_valid <= acc_valid && judge_hit;
         if (acc_valid) begin
            viol_cause <= judge_cause;
            acc_phys   <= phys;
         end
      end
   end

   assert_pulse_follows_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid |-> $past(acc_valid));

   assert_wrap_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_addr > WRAP_PT) |=>
      ({1'b0, acc_phys} + WRAP_PT == $past(acc_addr)));

endmodule

// File: tb/stor_prot_chk_bench.sv
module stor_prot_chk_bench;

   localparam int REQ_W  = 3;
   localparam int UIDX_W = 5;
   localparam int LVL_W  = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prot_en = 1'b0;
   logic        acc_valid = 1'b0;
   logic [2:0]  acc_req = '0;
   logic [1:0]  acc_kind = '0;
   logic [1:0]  acc_size = '0;
   logic [22:0] acc_addr = '0;
   logic        upd_valid = 1'b0;
   logic [2:0]  upd_req = '0;
   logic [1:0]  upd_sel = '0;
   logic [4:0]  upd_idx = '0;
   logic [2:0]  upd_data = '0;
   logic        exit_valid = 1'b0;
   logic [2:0]  exit_level = '0;
   logic        viol_valid;
   logic [1:0]  viol_cause;
   logic [21:0] acc_phys;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   stor_prot_chk u_stor_prot_chk (
      .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
      .acc_valid(acc_valid), .acc_req(acc_req), .acc_kind(acc_kind),
      .acc_size(acc_size), .acc_addr(acc_addr),
      .upd_valid(upd_valid), .upd_req(upd_req), .upd_sel(upd_sel),
      .upd_idx(upd_idx), .upd_data(upd_data),
      .exit_valid(exit_valid), .exit_level(exit_level),
      .viol_valid(viol_valid), .viol_cause(viol_cause), .acc_phys(acc_phys)
   );

   typedef struct packed {
      logic        pe;
      logic [2:0]  req;
      logic [1:0]  kind;
      logic [1:0]  size;
      logic [22:0] addr;
      logic        ev;
      logic [1:0]  ec;
      logic [21:0] ephys;
      logic [3:0]  rtag;
   } vec_t;

   // kind: 0 fetch 1 read 2 write; size: 0 byte 1 half 2 full
   localparam int NVEC = 16;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 3'd0, 2'd0, 2'd2, 23'h000000, 1'b0, 2'd0, 22'h000000, 4'd1}, // R1 exact match
      '{1'b1, 3'd0, 2'd0, 2'd2, 23'h000800, 1'b1, 2'd1, 22'h000800, 4'd1}, // R1 key 7 no escape
      '{1'b1, 3'd0, 2'd2, 2'd0, 23'h000801, 1'b0, 2'd0, 22'h000801, 4'd2}, // R2 open key 7
      '{1'b1, 3'd4, 2'd2, 2'd0, 23'h001000, 1'b1, 2'd2, 22'h001000, 4'd3}, // R3 user 0 on ro
      '{1'b1, 3'd1, 2'd2, 2'd1, 23'h001002, 1'b1, 2'd2, 22'h001002, 4'd3}, // R3 match on ro
      '{1'b1, 3'd0, 2'd2, 2'd0, 23'h001003, 1'b1, 2'd1, 22'h001003, 4'd7}, // R7 key over ro
      '{1'b1, 3'd0, 2'd1, 2'd0, 23'h001804, 1'b1, 2'd3, 22'h001804, 4'd4}, // R4 ae flag
      '{1'b1, 3'd0, 2'd1, 2'd1, 23'h000001, 1'b1, 2'd0, 22'h000001, 4'd6}, // R6 odd half
      '{1'b1, 3'd0, 2'd1, 2'd0, 23'h010000, 1'b1, 2'd3, 22'h010000, 4'd4}, // R4 first uninstalled
      '{1'b1, 3'd4, 2'd2, 2'd0, 23'h000000, 1'b0, 2'd0, 22'h000000, 4'd2}, // R2 user key 0
      '{1'b1, 3'd1, 2'd1, 2'd0, 23'h000000, 1'b0, 2'd0, 22'h000000, 4'd2}, // R2 read unchecked
      '{1'b1, 3'd0, 2'd1, 2'd0, 23'h400005, 1'b1, 2'd3, 22'h000006, 4'd5}, // R5 wrap, enabled
      '{1'b0, 3'd0, 2'd1, 2'd0, 23'h400005, 1'b0, 2'd0, 22'h000006, 4'd5}, // R5 wrap, disabled
      '{1'b0, 3'd0, 2'd1, 2'd0, 23'h3FFFFF, 1'b1, 2'd3, 22'h3FFFFF, 4'd5}, // R5 no wrap at top
      '{1'b1, 3'd0, 2'd1, 2'd2, 23'h001801, 1'b1, 2'd3, 22'h001801, 4'd7}, // R7 addr over align
      '{1'b1, 3'd0, 2'd0, 2'd1, 23'h000801, 1'b1, 2'd0, 22'h000801, 4'd7}  // R7 align over key
   };

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
      end
   endtask

   task automatic access(input logic pe, input logic [2:0] rq, input logic [1:0] k,
                         input logic [1:0] sz, input logic [22:0] a);
      @(negedge clk);
      prot_en = pe; acc_valid = 1'b1; acc_req = rq; acc_kind = k; acc_size = sz; acc_addr = a;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic update(input logic [2:0] rq, input logic [1:0] sel,
                         input logic [4:0] idx, input logic [2:0] d);
      @(negedge clk);
      upd_valid = 1'b1; upd_req = rq; upd_sel = sel; upd_idx = idx; upd_data = d;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   task automatic expect_result(input string rq, input logic ev, input logic [1:0] ec);
      check(viol_valid == ev, rq, "viol_valid", 32'(viol_valid), 32'(ev));
      if (ev) check(viol_cause == ec, rq, "viol_cause", 32'(viol_cause), 32'(ec));
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual running expected done");
         report();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(viol_valid == 1'b0, "R11", "viol_valid in reset", 32'(viol_valid), 0);
      rst_n = 1'b1;

      // R11: all keys and flags zero after reset
      access(1'b1, 3'd0, 2'd0, 2'd2, 23'h000800);
      expect_result("R11", 1'b0, 2'd0);
      access(1'b1, 3'd5, 2'd2, 2'd0, 23'h001000);
      expect_result("R11", 1'b0, 2'd0);

      // setup through privileged level 5 (requester 4, key 0): R9
      update(3'd4, 2'd0, 5'd0, 3'd3);
      update(3'd4, 2'd0, 5'd1, 3'd5);
      update(3'd4, 2'd1, 5'd0, 3'd3);
      update(3'd4, 2'd1, 5'd1, 3'd7);
      update(3'd4, 2'd1, 5'd2, 3'd5);
      update(3'd4, 2'd2, 5'd2, 3'd1);
      update(3'd4, 2'd3, 5'd3, 3'd1);
      update(3'd4, 2'd1, 5'd4, 3'd2);

      for (int i = 0; i < NVEC; i++) begin
         string tg;
         tg = $sformatf("R%0d vec%0d", VECS[i].rtag, i);
         access(VECS[i].pe, VECS[i].req, VECS[i].kind, VECS[i].size, VECS[i].addr);
         expect_result(tg, VECS[i].ev, VECS[i].ec);
         check(acc_phys == VECS[i].ephys, tg, "acc_phys", 32'(acc_phys), 32'(VECS[i].ephys));
         @(negedge clk);
         check(viol_valid == 1'b0, "R8", "pulse width", 32'(viol_valid), 0);
      end

      // R9: unprivileged requester 0 (key 3) cannot rewrite block 0 key
      update(3'd0, 2'd1, 5'd0, 3'd1);
      access(1'b1, 3'd0, 2'd0, 2'd2, 23'h000010);
      expect_result("R9 refused update", 1'b0, 2'd0);

      // R10: exit on level 2 beats a same-cycle update of requester 1's key
      @(negedge clk);
      upd_valid = 1'b1; upd_req = 3'd5; upd_sel = 2'd0; upd_idx = 5'd1; upd_data = 3'd6;
      exit_valid = 1'b1; exit_level = 3'd2;
      @(negedge clk);
      upd_valid = 1'b0; exit_valid = 1'b0;
      access(1'b1, 3'd1, 2'd2, 2'd0, 23'h001000);
      expect_result("R10 exit wins", 1'b1, 2'd2);

      // R10: exit on level 1 clears requester 0 key
      @(negedge clk);
      exit_valid = 1'b1; exit_level = 3'd1;
      @(negedge clk);
      exit_valid = 1'b0;
      access(1'b1, 3'd0, 2'd0, 2'd2, 23'h000000);
      expect_result("R10 level1 cleared", 1'b1, 2'd1);

      // R10: exit on last level keeps its key
      update(3'd4, 2'd0, 5'd4, 3'd2);
      @(negedge clk);
      exit_valid = 1'b1; exit_level = 3'd5;
      @(negedge clk);
      exit_valid = 1'b0;
      access(1'b1, 3'd4, 2'd0, 2'd2, 23'h002000);
      expect_result("R10 level5 kept", 1'b0, 2'd0);

      // R8: no pulse without an access
      @(negedge clk);
      check(viol_valid == 1'b0, "R8", "idle", 32'(viol_valid), 0);

      finished = 1'b1;
      report();
   end

endmodule